// File: doc/BRIEF.md
# Bit-Mapped Monochrome Raster Controller

This block drives a 256 x 192 monochrome raster from a byte-wide frame store that it shares with a host. It keeps a horizontal pixel counter and a vertical line counter. From these it derives horizontal and vertical blanking and sync, and it produces a one-bit video stream that is ready for an external summing network. Eight pixels are packed in each byte, so one frame fills 6144 bytes. Each byte is fetched from memory during the byte period before it is shown. It is then parallel-loaded into a shift register that gives up one pixel per clock, leftmost pixel first.

Every 8-clock byte period is split into two halves. In the first four clocks the host may write one byte. The display fetch is made in the second four clocks. A host write request is held until the next host half comes round, and the write is confirmed with a one-clock acknowledge. A reverse-video input inverts the picture. Blanking always forces black. Every sync, blank, slot and video output leaves the block straight from a flip-flop, so none of them can glitch.

Top module: `mono_raster_ctrl`

## Requirements
- R1: While reset is high, h_count, v_count, hblank, vblank, hsync, vsync, disp_slot, video, mem_rd, mem_we and host_ack are all 0.
- R2: h_count advances by one each clock and goes from 319 back to 0. v_count advances only on that wrap, and goes from 261 back to 0.
- R3: hblank is 1 exactly while h_count is in 256..319.
- R4: hsync is 1 exactly while h_count is in 271..294.
- R5: vblank is 1 exactly while v_count is in 192..261. vsync is 1 exactly while v_count is in 200..202.
- R6: disp_slot is 1 exactly when h_count mod 8 is in 4..7 (display half) and 0 when it is in 0..3 (host half).
- R7: mem_rd is 1 for the single clock where h_count mod 8 = 6, and only when the next 8-pixel group is visible. At that clock, mem_addr = {row[7:0], byte column[4:0]} of that next group. At h_count 318 this is column 0 of the next line.
- R8: While h_count = x and v_count = y are both in the visible area, video equals bit (7 - x mod 8) of the byte at address {y[7:0], x[7:3]}. Bit 7 is the leftmost pixel.
- R9: With rev_video held at 1, every visible pixel is the inverse of its stored bit.
- R10: video is 0 whenever hblank or vblank is 1, for either value of rev_video.
- R11: A host write drives mem_we with host_addr and host_wdata. It happens only at a clock where h_count mod 8 < 4, namely the first such clock after the held request is first sampled. The byte is then in memory.
- R12: host_ack is 1 only in the write clock, for one clock. A request dropped on the acknowledge causes no second write.
- R13: mem_rd and mem_we are never 1 in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Asynchronous reset, active high |
| rev_video | input | 1 | 1 inverts visible pixels |
| host_req | input | 1 | Host write request, held until host_ack |
| host_addr | input | 13 | Host write byte address |
| host_wdata | input | 8 | Host write byte |
| host_ack | output | 1 | One-clock write confirmation |
| mem_addr | output | 13 | Frame store byte address |
| mem_rd | output | 1 | Display read strobe (data returned next clock) |
| mem_we | output | 1 | Host write strobe |
| mem_wdata | output | 8 | Frame store write data |
| mem_rdata | input | 8 | Frame store read data, one clock after mem_rd |
| h_count | output | 9 | Pixel position in line |
| v_count | output | 9 | Line position in frame |
| hblank | output | 1 | Horizontal blanking |
| vblank | output | 1 | Vertical blanking |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| disp_slot | output | 1 | 1 in the display half of a byte period |
| video | output | 1 | Pixel bit |

## Verification
Several properties are checked on every clock. These cover the counter wrap and the stillness of the line counter between wraps, the fact that each sync sits inside its own blanking, that the two memory strobes never overlap, that writes fall only in host halves, that the acknowledge is single, and that blanking forces black. Other points need the bench's scenarios. Only those scenarios can show the exact sync and blank windows and the address of each prefetch. They also show that each pixel carries the right stored bit in the right order under both video polarities, and how many clocks a host request waits when it arrives in the display half or at the end of a line.

// File: rtl/raster_pkg.sv
package raster_pkg;
    // Which party owns the memory port in the current half byte period.
    typedef enum logic {SLOT_HOST = 1'b0, SLOT_DISP = 1'b1} slot_e;
    // Pixels packed into one memory byte.
    localparam int PIX_PER_BYTE = 8;
endpackage

// File: rtl/raster_timing.sv
module raster_timing
    import raster_pkg::*;
#(
    parameter int H_ACTIVE = 256,
    parameter int H_TOTAL  = 320,
    parameter int HS_START = 271,
    parameter int HS_STOP  = 295,
    parameter int V_ACTIVE = 192,
    parameter int V_TOTAL  = 262,
    parameter int VS_START = 200,
    parameter int VS_LINES = 3,
    parameter int HW = $clog2(H_TOTAL),
    parameter int VW = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [HW-1:0] h_count_o,
    output logic [VW-1:0] v_count_o,
    output logic          hblank_o,
    output logic          vblank_o,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          disp_slot_o,
    output logic [HW-1:0] h_next_o,
    output logic [VW-1:0] v_next_o,
    output logic          active_next_o
);
    localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
    localparam logic [HW-1:0] H_ACT  = HW'(H_ACTIVE);
    localparam logic [HW-1:0] HS_ON  = HW'(HS_START);
    localparam logic [HW-1:0] HS_OFF = HW'(HS_STOP);
    localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
    localparam logic [VW-1:0] V_ACT  = VW'(V_ACTIVE);
    localparam logic [VW-1:0] VS_ON  = VW'(VS_START);
    localparam logic [VW-1:0] VS_OFF = VW'(VS_START + VS_LINES);
    localparam int SLOT_BIT = $clog2(PIX_PER_BYTE) - 1;

    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
        logic          hblank;
        logic          vblank;
        logic          hsync;
        logic          vsync;
        slot_e         slot;
    } tstate_t;

    tstate_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.h == H_LAST) begin
            s_d.h = '0;
            s_d.v = (s_q.v == V_LAST) ? '0 : s_q.v + 1'b1;
        end else begin
            s_d.h = s_q.h + 1'b1;
        end
        s_d.hblank = (s_d.h >= H_ACT);
        s_d.hsync  = (s_d.h >= HS_ON) && (s_d.h < HS_OFF);
        s_d.vblank = (s_d.v >= V_ACT);
        s_d.vsync  = (s_d.v >= VS_ON) && (s_d.v < VS_OFF);
        s_d.slot   = s_d.h[SLOT_BIT] ? SLOT_DISP : SLOT_HOST;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign h_count_o     = s_q.h;
    assign v_count_o     = s_q.v;
    assign hblank_o      = s_q.hblank;
    assign vblank_o      = s_q.vblank;
    assign hsync_o       = s_q.hsync;
    assign vsync_o       = s_q.vsync;
    assign disp_slot_o   = (s_q.slot == SLOT_DISP);
    assign h_next_o      = s_d.h;
    assign v_next_o      = s_d.v;
    assign active_next_o = !s_d.hblank && !s_d.vblank;

    // R2
    h_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (h_count_o == H_LAST) |=> (h_count_o == '0));
    // R2
    v_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (h_count_o != H_LAST) |=> $stable(v_count_o));
    // R4
    hsync_in_blank_chk: assert property (@(posedge clk) disable iff (rst)
        hsync_o |-> hblank_o);
    // R5
    vsync_in_blank_chk: assert property (@(posedge clk) disable iff (rst)
        vsync_o |-> vblank_o);
endmodule

// File: rtl/fetch_arbiter.sv
module fetch_arbiter
    import raster_pkg::*;
#(
    parameter int H_ACTIVE = 256,
    parameter int H_TOTAL  = 320,
    parameter int V_ACTIVE = 192,
    parameter int V_TOTAL  = 262,
    parameter int HW = 9,
    parameter int VW = 9,
    parameter int AW = 13,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [HW-1:0] h_count_i,
    input  logic [HW-1:0] h_next_i,
    input  logic [VW-1:0] v_next_i,
    input  logic          host_req_i,
    input  logic [AW-1:0] host_addr_i,
    input  logic [DW-1:0] host_wdata_i,
    output logic          host_ack_o,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_rd_o,
    output logic          mem_we_o,
    output logic [DW-1:0] mem_wdata_o
);
    localparam int PBW      = $clog2(PIX_PER_BYTE);
    localparam int CW       = $clog2(H_ACTIVE / PIX_PER_BYTE);
    localparam int RW       = AW - CW;
    localparam int SLOT_BIT = PBW - 1;
    localparam logic [PBW-1:0] FETCH_PH   = PBW'(PIX_PER_BYTE - 2);
    localparam logic [HW-1:0]  H_LINE_LIM = HW'(H_ACTIVE - PIX_PER_BYTE);
    localparam logic [HW-1:0]  H_WRAP_LO  = HW'(H_TOTAL - PIX_PER_BYTE);
    localparam logic [VW-1:0]  V_ACT      = VW'(V_ACTIVE);
    localparam logic [VW-1:0]  V_LAST     = VW'(V_TOTAL - 1);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          rd;
        logic          we;
        logic          ack;
        logic [DW-1:0] wdata;
    } astate_t;

    astate_t a_d, a_q;
    logic [VW-1:0] v_after;
    logic          in_line, at_wrap, fetch, host_go;
    logic [CW-1:0] col;
    logic [RW-1:0] row;

    always_comb begin
        v_after = (v_next_i == V_LAST) ? '0 : v_next_i + 1'b1;
        in_line = (h_next_i < H_LINE_LIM) && (v_next_i < V_ACT);
        at_wrap = (h_next_i >= H_WRAP_LO) && (v_after < V_ACT);
        fetch   = (h_next_i[PBW-1:0] == FETCH_PH) && (in_line || at_wrap);
        host_go = !h_next_i[SLOT_BIT] && host_req_i && !a_q.ack;
        col     = at_wrap ? '0 : h_next_i[CW+PBW-1:PBW] + 1'b1;
        row     = at_wrap ? v_after[RW-1:0] : v_next_i[RW-1:0];

        a_d.rd    = fetch;
        a_d.we    = host_go;
        a_d.ack   = host_go;
        a_d.addr  = fetch ? {row, col} : (host_go ? host_addr_i : '0);
        a_d.wdata = host_go ? host_wdata_i : '0;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) a_q <= '0;
        else     a_q <= a_d;
    end

    assign mem_addr_o  = a_q.addr;
    assign mem_rd_o    = a_q.rd;
    assign mem_we_o    = a_q.we;
    assign mem_wdata_o = a_q.wdata;
    assign host_ack_o  = a_q.ack;

    // R13
    port_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_o && mem_we_o));
    // R11
    host_slot_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> !h_count_i[SLOT_BIT]);
    // R12
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        host_ack_o |=> !host_ack_o);
endmodule

// File: rtl/pixel_shifter.sv
module pixel_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic          active_i,
    input  logic          rev_i,
    input  logic [DW-1:0] rdata_i,
    input  logic          hblank_i,
    input  logic          vblank_i,
    output logic          video_o
);
    typedef struct packed {
        logic [DW-1:0] sh;
        logic          vid;
    } pstate_t;

    pstate_t p_d, p_q;
    logic    cur_bit;

    always_comb begin
        cur_bit  = load_i ? rdata_i[DW-1] : p_q.sh[DW-1];
        p_d.sh   = load_i ? {rdata_i[DW-2:0], 1'b0} : {p_q.sh[DW-2:0], 1'b0};
        p_d.vid  = active_i && (cur_bit ^ rev_i);
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) p_q <= '0;
        else     p_q <= p_d;
    end

    assign video_o = p_q.vid;

    // R10
    blank_black_chk: assert property (@(posedge clk) disable iff (rst)
        (hblank_i || vblank_i) |-> !video_o);
endmodule

// File: rtl/mono_raster_ctrl.sv
module mono_raster_ctrl
    import raster_pkg::*;
#(
    parameter int H_ACTIVE = 256,
    parameter int H_TOTAL  = 320,
    parameter int HS_START = 271,
    parameter int HS_STOP  = 295,
    parameter int V_ACTIVE = 192,
    parameter int V_TOTAL  = 262,
    parameter int VS_START = 200,
    parameter int VS_LINES = 3,
    parameter int HW = $clog2(H_TOTAL),
    parameter int VW = $clog2(V_TOTAL),
    parameter int AW = $clog2(V_ACTIVE) + $clog2(H_ACTIVE / PIX_PER_BYTE),
    parameter int DW = PIX_PER_BYTE
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rev_video,
    input  logic          host_req,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic          host_ack,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [HW-1:0] h_count,
    output logic [VW-1:0] v_count,
    output logic          hblank,
    output logic          vblank,
    output logic          hsync,
    output logic          vsync,
    output logic          disp_slot,
    output logic          video
);
    localparam int PBW = $clog2(PIX_PER_BYTE);

    logic [HW-1:0] h_next;
    logic [VW-1:0] v_next;
    logic          active_next;
    logic          byte_load;

    raster_timing #(
        .H_ACTIVE(H_ACTIVE), .H_TOTAL(H_TOTAL), .HS_START(HS_START), .HS_STOP(HS_STOP),
        .V_ACTIVE(V_ACTIVE), .V_TOTAL(V_TOTAL), .VS_START(VS_START), .VS_LINES(VS_LINES),
        .HW(HW), .VW(VW)
    ) u_timing (
        .clk(clk), .rst(rst),
        .h_count_o(h_count), .v_count_o(v_count),
        .hblank_o(hblank), .vblank_o(vblank), .hsync_o(hsync), .vsync_o(vsync),
        .disp_slot_o(disp_slot),
        .h_next_o(h_next), .v_next_o(v_next), .active_next_o(active_next)
    );

    fetch_arbiter #(
        .H_ACTIVE(H_ACTIVE), .H_TOTAL(H_TOTAL), .V_ACTIVE(V_ACTIVE), .V_TOTAL(V_TOTAL),
        .HW(HW), .VW(VW), .AW(AW), .DW(DW)
    ) u_arb (
        .clk(clk), .rst(rst),
        .h_count_i(h_count), .h_next_i(h_next), .v_next_i(v_next),
        .host_req_i(host_req), .host_addr_i(host_addr), .host_wdata_i(host_wdata),
        .host_ack_o(host_ack),
        .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata)
    );

    assign byte_load = (h_next[PBW-1:0] == '0);

    pixel_shifter #(.DW(DW)) u_shift (
        .clk(clk), .rst(rst),
        .load_i(byte_load), .active_i(active_next), .rev_i(rev_video),
        .rdata_i(mem_rdata), .hblank_i(hblank), .vblank_i(vblank),
        .video_o(video)
    );
endmodule

// File: tb/mono_raster_ctrl_bench.sv
`timescale 1ns/1ps
module mono_raster_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rev_video = 1'b0;
    logic        host_req = 1'b0;
    logic [12:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_ack;
    logic [12:0] mem_addr;
    logic        mem_rd, mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic [8:0]  h_count, v_count;
    logic        hblank, vblank, hsync, vsync, disp_slot, video;

    int n_chk = 0;
    int n_fail = 0;
    int eh = 0;
    int ev = 0;
    bit vchk = 1'b0;

    always #10 clk = ~clk;

    mono_raster_ctrl u_mono_raster_ctrl (
        .clk(clk), .rst(rst), .rev_video(rev_video),
        .host_req(host_req), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_ack(host_ack),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .h_count(h_count), .v_count(v_count),
        .hblank(hblank), .vblank(vblank), .hsync(hsync), .vsync(vsync),
        .disp_slot(disp_slot), .video(video)
    );

    // Frame store model: computed base pattern overlaid by written bytes.
    bit         ov_set [0:8191];
    logic [7:0] ov_val [0:8191];

    function automatic logic [7:0] patt(input int a);
        int t;
        t = ((a * 29) / 4) ^ a ^ (a >> 7);
        return t[7:0];
    endfunction

    function automatic logic [7:0] rbyte(input int a);
        return ov_set[a] ? ov_val[a] : patt(a);
    endfunction

    always @(posedge clk) begin
        if (mem_we) begin
            ov_set[mem_addr] <= 1'b1;
            ov_val[mem_addr] <= mem_wdata;
        end
        if (mem_rd) mem_rdata <= rbyte(int'(mem_addr));
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at h=%0d v=%0d: actual %0d expected %0d", tag, eh, ev, act, exp);
        end
    endtask

    task automatic check_cycle();
        int va;
        int eaddr;
        bit erd;
        bit vis;
        bit ebit;
        logic [7:0] bt;
        chk(int'(h_count) == eh, "R2", int'(h_count), eh);
        chk(int'(v_count) == ev, "R2", int'(v_count), ev);
        chk(hblank == (eh >= 256), "R3", int'(hblank), int'(eh >= 256));
        chk(hsync == (eh >= 271 && eh <= 294), "R4", int'(hsync), int'(eh >= 271 && eh <= 294));
        chk(vblank == (ev >= 192), "R5", int'(vblank), int'(ev >= 192));
        chk(vsync == (ev >= 200 && ev <= 202), "R5", int'(vsync), int'(ev >= 200 && ev <= 202));
        chk(disp_slot == ((eh % 8) >= 4), "R6", int'(disp_slot), int'((eh % 8) >= 4));
        va  = (ev == 261) ? 0 : ev + 1;
        erd = (eh % 8 == 6) && ((eh < 248 && ev < 192) || (eh >= 312 && va < 192));
        chk(mem_rd == erd, "R7", int'(mem_rd), int'(erd));
        if (erd) begin
            eaddr = (eh >= 312) ? va * 32 : ev * 32 + eh / 8 + 1;
            chk(int'(mem_addr) == eaddr, "R7", int'(mem_addr), eaddr);
        end
        chk(!(mem_rd && mem_we), "R13", int'(mem_rd && mem_we), 0);
        if (mem_we) chk((eh % 8) < 4, "R11", eh % 8, 0);
        if (vchk) begin
            vis = (eh < 256) && (ev < 192);
            ebit = 1'b0;
            if (vis) begin
                bt   = rbyte(ev * 32 + eh / 8);
                ebit = bt[7 - (eh % 8)] ^ rev_video;
            end
            chk(video == ebit, vis ? (rev_video ? "R9" : "R8") : "R10", int'(video), int'(ebit));
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (eh == 319) begin
            eh = 0;
            ev = (ev == 261) ? 0 : ev + 1;
        end else begin
            eh++;
        end
        check_cycle();
    endtask

    task automatic advance_to(input int h, input int v);
        while (!(eh == h && ev == v)) step();
    endtask

    // R1: outputs quiet while reset is held
    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(h_count == 0 && v_count == 0, "R1", int'(h_count) + int'(v_count), 0);
        chk(!hblank && !vblank && !hsync && !vsync, "R1",
            int'(hblank) + int'(vblank) + int'(hsync) + int'(vsync), 0);
        chk(!disp_slot && !video, "R1", int'(disp_slot) + int'(video), 0);
        chk(!mem_rd && !mem_we && !host_ack, "R1", int'(mem_rd) + int'(mem_we) + int'(host_ack), 0);
        rst = 1'b0;
        eh = 0;
        ev = 0;
        check_cycle();
    endtask

    // R11, R12: one held write, acknowledged in the first host-half clock
    task automatic host_write(input int addr, input logic [7:0] data);
        int n;
        int ea;
        bit got;
        host_addr  = 13'(addr);
        host_wdata = data;
        host_req   = 1'b1;
        n = eh + 1;
        while (((n % 320) % 8) >= 4) n++;
        ea  = n % 320;
        got = 1'b0;
        for (int i = 0; i < 16 && !got; i++) begin
            step();
            if (host_ack) got = 1'b1;
        end
        chk(got, "R11", int'(got), 1);
        chk(eh == ea, "R11", eh, ea);
        chk(mem_we, "R11", int'(mem_we), 1);
        chk(int'(mem_addr) == addr, "R11", int'(mem_addr), addr);
        chk(mem_wdata == data, "R11", int'(mem_wdata), int'(data));
        host_req = 1'b0;
        step();
        chk(!host_ack, "R12", int'(host_ack), 0);
        chk(!mem_we, "R12", int'(mem_we), 0);
        chk(rbyte(addr) == data, "R11", int'(rbyte(addr)), int'(data));
    endtask

    task automatic t_host_writes();
        advance_to(3, 2);
        host_write(10 * 32 + 3, 8'hA5);     // request in host half, lands at next group
        advance_to(16, 3);
        host_write(100 * 32 + 31, 8'h3C);   // immediate host slot
        advance_to(7, 4);
        host_write(191 * 32 + 0, 8'hFF);    // arrives at end of display half
        advance_to(318, 5);
        host_write(0 * 32 + 17, 8'h01);     // waits across the line wrap
    endtask

    // R2, R5: run out frame 0, check the frame wrap
    task automatic t_frame_timing();
        advance_to(319, 261);
        vchk = 1'b1;
        step();
        chk(h_count == 0 && v_count == 0, "R2", int'(h_count) + int'(v_count), 0);
    endtask

    // R8: normal video over the first half of frame 1
    task automatic t_video_normal();
        advance_to(300, 95);
        chk(video == 1'b0, "R10", int'(video), 0);
    endtask

    // R9, R10: reverse video over the rest, including vertical blanking
    task automatic t_video_reverse();
        rev_video = 1'b1;
        advance_to(319, 191);
        step();
        chk(vblank && !video, "R10", int'(video), 0);
        advance_to(0, 201);
    endtask

    initial begin
        t_reset();
        t_host_writes();
        t_frame_timing();
        t_video_normal();
        t_video_reverse();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R2: watchdog expired, actual hung expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule